// File: doc/BRIEF.md
# PMIC Register Write Engine over I2C

This block is a small write-only I2C master that a power-management sequence uses to set one register in an external regulator device. Software posts a single packed command word holding the 7-bit target address, the register index and the data byte, with a go flag. The engine then produces a START condition, the address byte with the write direction bit, the register byte and the data byte, each followed by an acknowledge slot, and closes with a STOP condition. When the STOP has completed, the engine clears the go flag itself, so software can poll for completion.

The serial clock is timed from two 8-bit counts in a clock register. The SCL high time is the programmed count plus a fixed offset of 5 system clocks, and the low time is the count plus a fixed offset of 7. Settings near 40 % high and 60 % low suit standard and fast mode, up to 400 kHz. Both bus lines are open drain. The block drives only a pull-low enable for each line and reads each line back through an input.

The register port is one 32-bit word. `reg_sel` = 0 selects the command word and `reg_sel` = 1 selects the clock word. A write happens in any cycle with `reg_we` high. The read data is combinational on `reg_sel`.

Top module: `i2cw_pmic_writer`

## Requirements
- R1: Command word layout is: target address in bits [6:0], register index in bits [15:8], data in bits [23:16]. Bit 7 reads 0. The bus carries {address, 0} first, then the register index, then the data, each most-significant bit first.
- R2: Writing the command word with bit 24 = 1 while the engine is idle starts one transfer. Bit 24 reads 1 from the next cycle until the STOP and the bus-free time that follows it have completed, and then reads 0. Writing with bit 24 = 0 only stores the fields and starts nothing.
- R3: While bit 24 reads 1, a write to the command word has no effect. The fields read back unchanged, the bytes on the bus are those of the running command, and no second transfer follows.
- R4: During address, data and acknowledge bits, SCL stays high for exactly clock-word bits [7:0] + 5 system clocks.
- R5: Every SCL low phase, including the one before STOP, lasts exactly clock-word bits [15:8] + 7 system clocks.
- R6: SDA changes while SCL is high only twice per transfer: it falls once for START before the first SCL fall, and it rises once for STOP at the end. Each transfer shows exactly one START and one STOP.
- R7: The engine samples the acknowledge during the ninth SCL high phase of each byte. A high level (NACK) on any byte makes the engine skip the remaining bytes and go straight to STOP. It also sets the error flag at command-word bit 25 and clears bit 24.
- R8: The error flag stays set until the next write that starts a transfer, and that write clears it. Writes with bit 24 = 0 leave it unchanged.
- R9: After reset, both pull-low enables are inactive, the command word reads 0 and the clock word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = command word, 1 = clock word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word |
| scl_i | input | 1 | Sensed SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench covers several corner cases, each with a distinct failure signature:
- **NACK position.** The bench NACKs the address byte, the register byte and the data byte in turn. An engine that ignored a NACK would clock out bytes after it. An engine that left the flag clear would report success for a failed write.
- **Command rewrite during a transfer.** A rewrite mid-transfer would corrupt the bytes on the bus or launch a second transfer.
- **Extreme clock counts.** With counts 0 and 255, an off-by-one in the reload value or an overflowing phase counter would show up as a wrong high or low width.
- **SDA edges while SCL is high.** A data change at the same edge as the SCL fall would register as a spurious START or STOP.
- **Sticky error flag.** The bench confirms the flag survives a plain field write and is cleared by the next start.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_LOW,
      PH_HIGH,
      PH_STOP_LOW,
      PH_STOP_HIGH,
      PH_FREE
   } i2cw_phase_e;

   localparam int unsigned XFER_BYTES = 3;
   localparam int unsigned GO_BIT     = 24;
   localparam int unsigned ERR_BIT    = 25;

endpackage

// File: rtl/i2cw_phase_timer.sv
module i2cw_phase_timer #(
   parameter int unsigned PW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] load_val,
   input  logic          adv,
   output logic          done
);

   logic [PW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (adv && (cnt != '0)) begin
         cnt <= cnt - PW'(1);
      end
   end

   assign done = adv && (cnt == '0);

   a_r4_reload_wins : assert property (@(posedge clk) disable iff (!rst_n)
      $past(load) |-> cnt == $past(load_val));

endmodule

// File: rtl/i2cw_byte_shifter.sv
module i2cw_byte_shifter #(
   parameter int unsigned NB = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [8*NB-1:0] frame,
   input  logic            adv,
   output logic            tx_bit,
   output logic            ack_slot,
   output logic            last_byte
);

   localparam int unsigned SW = 8 * NB;
   localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1;

   logic [SW-1:0] sr;
   logic [3:0]    bit_idx;
   logic [BW-1:0] byte_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr       <= '0;
         bit_idx  <= '0;
         byte_idx <= '0;
      end else if (load) begin
         sr       <= frame;
         bit_idx  <= '0;
         byte_idx <= '0;
      end else if (adv) begin
         if (bit_idx == 4'd8) begin
            bit_idx  <= '0;
            byte_idx <= byte_idx + BW'(1);
         end else begin
            sr      <= {sr[SW-2:0], 1'b0};
            bit_idx <= bit_idx + 4'd1;
         end
      end
   end

   assign tx_bit    = sr[SW-1];
   assign ack_slot  = (bit_idx == 4'd8);
   assign last_byte = (byte_idx == BW'(NB - 1));

   a_r1_bit_index_range : assert property (@(posedge clk) disable iff (!rst_n)
      bit_idx <= 4'd8);

endmodule

// File: rtl/i2cw_pmic_writer.sv
module i2cw_pmic_writer
   import i2cw_pkg::*;
#(
   parameter int unsigned HI_OFS   = 5,
   parameter int unsigned LO_OFS   = 7,
   parameter bit          WAIT_SCL = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic        reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        scl_i,
   output logic        scl_oe,
   input  logic        sda_i,
   output logic        sda_oe
);

   localparam int unsigned MAXOFS = (HI_OFS > LO_OFS) ? HI_OFS : LO_OFS;
   localparam int unsigned PW     = $clog2(255 + MAXOFS + 1);

   generate
      if (HI_OFS < 1 || LO_OFS < 2) begin : g_bad_offsets
         $error("i2cw_pmic_writer: HI_OFS must be >= 1 and LO_OFS >= 2");
      end
   endgenerate

   logic [6:0]    c_addr;
   logic [7:0]    c_reg, c_dat, t_hi, t_lo;
   logic          c_valid, c_err;
   i2cw_phase_e   st, st_nx;
   logic [PW-1:0] len_hi, len_lo, ld_val;
   logic          ld, tick, adv_en, sh_load, sh_adv, sda_q;
   logic          tx_bit, ack_slot, last_byte, cmd_take;
   logic          unused_wdata;

   assign unused_wdata = ^reg_wdata[31:25];
   assign cmd_take     = reg_we && !reg_sel && !c_valid;
   assign len_hi       = PW'(t_hi) + PW'(HI_OFS);
   assign len_lo       = PW'(t_lo) + PW'(LO_OFS);

   // command and clock words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_addr  <= '0;
         c_reg   <= '0;
         c_dat   <= '0;
         c_valid <= 1'b0;
         c_err   <= 1'b0;
         t_hi    <= '0;
         t_lo    <= '0;
      end else begin
         if (reg_we && reg_sel) begin
            t_hi <= reg_wdata[7:0];
            t_lo <= reg_wdata[15:8];
         end
         if (cmd_take) begin
            c_addr <= reg_wdata[6:0];
            c_reg  <= reg_wdata[15:8];
            c_dat  <= reg_wdata[23:16];
            if (reg_wdata[GO_BIT]) begin
               c_valid <= 1'b1;
               c_err   <= 1'b0;
            end
         end else if (st == PH_FREE && tick) begin
            c_valid <= 1'b0;
         end
         if (st == PH_HIGH && tick && ack_slot && sda_i) begin
            c_err <= 1'b1;
         end
      end
   end

   always_comb begin
      if (reg_sel) reg_rdata = {16'h0, t_lo, t_hi};
      else         reg_rdata = {6'h0, c_err, c_valid, c_dat, c_reg, 1'b0, c_addr};
   end

   // phase sequencer
   always_comb begin
      st_nx   = st;
      ld      = 1'b0;
      ld_val  = len_hi - PW'(1);
      sh_load = 1'b0;
      sh_adv  = 1'b0;
      case (st)
         PH_IDLE: if (c_valid) begin
            st_nx   = PH_START;
            ld      = 1'b1;
            sh_load = 1'b1;
         end
         PH_START: if (tick) begin
            st_nx  = PH_LOW;
            ld     = 1'b1;
            ld_val = len_lo - PW'(1);
         end
         PH_LOW: if (tick) begin
            st_nx = PH_HIGH;
            ld    = 1'b1;
         end
         PH_HIGH: if (tick) begin
            ld     = 1'b1;
            ld_val = len_lo - PW'(1);
            sh_adv = 1'b1;
            if (ack_slot && (sda_i || last_byte)) st_nx = PH_STOP_LOW;
            else                                  st_nx = PH_LOW;
         end
         PH_STOP_LOW: if (tick) begin
            st_nx = PH_STOP_HIGH;
            ld    = 1'b1;
         end
         PH_STOP_HIGH: if (tick) begin
            st_nx = PH_FREE;
            ld    = 1'b1;
         end
         PH_FREE: if (tick) st_nx = PH_IDLE;
         default: st_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= PH_IDLE;
         sda_q <= 1'b0;
      end else begin
         st <= st_nx;
         case (st)
            PH_IDLE:      if (c_valid) sda_q <= 1'b1;
            PH_LOW:       sda_q <= !ack_slot && !tx_bit;
            PH_STOP_LOW:  sda_q <= 1'b1;
            PH_STOP_HIGH: if (tick) sda_q <= 1'b0;
            default:      ;
         endcase
      end
   end

   assign scl_oe = (st == PH_LOW) || (st == PH_STOP_LOW);
   assign sda_oe = sda_q;

   generate
      if (WAIT_SCL) begin : g_wait_line
         assign adv_en = scl_oe ? 1'b1 : scl_i;
      end else begin : g_free_run
         assign adv_en = 1'b1;
      end
   endgenerate

   i2cw_phase_timer #(.PW(PW)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .adv      (adv_en),
      .done     (tick)
   );

   i2cw_byte_shifter #(.NB(XFER_BYTES)) shifter_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sh_load),
      .frame     ({c_addr, 1'b0, c_reg, c_dat}),
      .adv       (sh_adv),
      .tx_bit    (tx_bit),
      .ack_slot  (ack_slot),
      .last_byte (last_byte)
   );

   a_r6_release_only_at_stop : assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && !$past(scl_oe) && $fell(sda_oe)) |-> st == PH_FREE);

   a_r6_pull_only_at_start : assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && !$past(scl_oe) && $rose(sda_oe)) |-> st == PH_START);

   a_r3_fields_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      (c_valid && $past(c_valid)) |-> $stable({c_addr, c_reg, c_dat}));

   a_r2_go_drops_after_free : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(c_valid) |-> (st == PH_IDLE && $past(st) == PH_FREE));

   a_r7_error_heads_to_stop : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(c_err) |-> st == PH_STOP_LOW);

   a_r9_bus_quiet_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe |-> c_valid);

endmodule

// File: tb/i2cw_pmic_writer_tb.sv
module i2cw_pmic_writer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        scl_oe, sda_oe, scl_ln, sda_ln;
   logic        slv_pull = 1'b0;

   always #4 clk = ~clk;

   assign scl_ln = !scl_oe;
   assign sda_ln = !(sda_oe || slv_pull);

   i2cw_pmic_writer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .scl_i     (scl_ln),
      .scl_oe    (scl_oe),
      .sda_i     (sda_ln),
      .sda_oe    (sda_oe)
   );

   int n_vec = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // behavioural slave and bus monitor
   logic [6:0] slv_addr = 7'h5A;
   int         slv_nack_at = -1;
   int         th_exp = 5, tl_exp = 7;
   int         n_start = 0, n_stop = 0;
   byte        rx[$];
   logic       p_scl = 1'b1, p_sda = 1'b1;
   int         bitc = 0, bytec = 0, hcnt = 0, lcnt = 0;
   bit         had_rise = 0, had_fall = 0, slv_sel = 0;
   logic [7:0] sh = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_scl && scl_ln && p_sda && !sda_ln) begin
            n_start++; bitc = 0; bytec = 0; slv_pull <= 1'b0; had_rise = 0;
         end else if (p_scl && scl_ln && !p_sda && sda_ln) begin
            n_stop++; had_rise = 0; had_fall = 0; slv_pull <= 1'b0;
         end
         if (!p_scl && scl_ln) begin
            if (had_fall) chk(lcnt == tl_exp, "R5", "SCL low width", lcnt, tl_exp);
            had_fall = 0; had_rise = 1; hcnt = 0;
            if (bitc < 8) begin
               sh = {sh[6:0], sda_ln};
               bitc++;
               if (bitc == 8) rx.push_back(sh);
            end else begin
               bitc = 9;
            end
         end
         if (p_scl && !scl_ln) begin
            if (had_rise) chk(hcnt == th_exp, "R4", "SCL high width", hcnt, th_exp);
            had_rise = 0; had_fall = 1; lcnt = 0;
            if (bitc == 8) begin
               if (bytec == 0) slv_sel = (sh[7:1] == slv_addr) && !sh[0];
               slv_pull <= slv_sel && (bytec != slv_nack_at);
            end else if (bitc == 9) begin
               slv_pull <= 1'b0; bitc = 0; bytec++;
            end
         end
         if (scl_ln) hcnt++; else lcnt++;
         p_scl = scl_ln;
         p_sda = sda_ln;
      end
   end

   task automatic wr(input logic sel, input logic [31:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [31:0] v);
      @(negedge clk);
      reg_sel = sel;
      #1 v = reg_rdata;
   endtask

   task automatic set_clk(input int hi, input int lo);
      logic [31:0] v;
      wr(1'b1, {16'h0, lo[7:0], hi[7:0]});
      th_exp = hi + 5; tl_exp = lo + 7;
      rd(1'b1, v);
      chk(v == {16'h0, lo[7:0], hi[7:0]}, "R4", "clock word readback", v, {lo[7:0], hi[7:0]});
   endtask

   task automatic xfer(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                       input bit poke, input int exp_n, input bit exp_err);
      logic [31:0] v;
      int s0, p0;
      byte exp_b[3];
      bit done;
      exp_b[0] = {a, 1'b0}; exp_b[1] = r; exp_b[2] = d;
      rx.delete();
      #1 s0 = n_start; p0 = n_stop;
      wr(1'b0, {7'h0, 1'b1, d, r, 1'b0, a});
      rd(1'b0, v);
      chk(v[24] == 1'b1, "R2", "go flag set after start", v[24], 1);
      chk(v[25] == 1'b0, "R8", "error cleared by start", v[25], 0);
      if (poke) begin
         repeat (50) @(negedge clk);
         wr(1'b0, {7'h0, 1'b1, ~d, ~r, 1'b0, ~a});
         rd(1'b0, v);
         chk(v[23:0] == {d, r, 1'b0, a}, "R3", "fields kept while busy", v[23:0], {d, r, 1'b0, a});
      end
      done = 0;
      for (int k = 0; k < 60000 && !done; k++) begin
         rd(1'b0, v);
         if (!v[24]) done = 1;
      end
      chk(done, "R2", "go flag cleared at end", v[24], 0);
      chk(v[25] == exp_err, "R7", "error flag after transfer", v[25], exp_err);
      chk(v[23:0] == {d, r, 1'b0, a}, "R1", "command fields readback", v[23:0], {d, r, 1'b0, a});
      chk(rx.size() == exp_n, "R7", "bytes seen on bus", rx.size(), exp_n);
      for (int i = 0; i < rx.size() && i < 3; i++)
         chk(rx[i] == exp_b[i], "R1", $sformatf("byte %0d", i), rx[i], exp_b[i]);
      chk(n_start - s0 == 1, "R6", "START count", n_start - s0, 1);
      chk(n_stop - p0 == 1, "R6", "STOP count", n_stop - p0, 1);
      repeat (40) @(negedge clk);
      #1 chk(n_start - s0 == 1, "R3", "no extra transfer", n_start - s0, 1);
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R9 reset state
      #1 chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R9", "lines released", {scl_oe, sda_oe}, 0);
      rd(1'b0, v); chk(v == 32'h0, "R9", "command word reset", v, 0);
      rd(1'b1, v); chk(v == 32'h0, "R9", "clock word reset", v, 0);
      // R2 field write without go
      wr(1'b0, 32'h00A5_3C5A);
      repeat (20) @(negedge clk);
      rd(1'b0, v); chk(v == 32'h00A5_3C5A, "R2", "fields stored, no go", v, 32'h00A5_3C5A);
      #1 chk(n_start == 0, "R2", "no START without go", n_start, 0);
      // nominal 40/60 timing
      set_clk(11, 17);
      slv_addr = 7'h5A; slv_nack_at = -1;
      xfer(7'h5A, 8'h3C, 8'hA5, 1'b0, 3, 1'b0);
      // R3 rewrite while busy
      slv_addr = 7'h12;
      xfer(7'h12, 8'h80, 8'h01, 1'b1, 3, 1'b0);
      // R7 address NACK
      xfer(7'h13, 8'h55, 8'hAA, 1'b0, 1, 1'b1);
      // R8 sticky across a plain field write
      wr(1'b0, 32'h0000_0013);
      rd(1'b0, v); chk(v[25] == 1'b1, "R8", "error sticky", v[25], 1);
      // R7 NACK on data and on register byte
      slv_nack_at = 2;
      xfer(7'h12, 8'h0F, 8'hF0, 1'b0, 3, 1'b1);
      slv_nack_at = 1;
      xfer(7'h12, 8'hC3, 8'h3C, 1'b0, 2, 1'b1);
      // boundary clock counts
      slv_nack_at = -1; slv_addr = 7'h7F;
      set_clk(0, 0);
      xfer(7'h7F, 8'hFF, 8'h00, 1'b0, 3, 1'b0);
      slv_addr = 7'h00;
      set_clk(255, 255);
      xfer(7'h00, 8'h00, 8'hFF, 1'b0, 3, 1'b0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule